// File: doc/BRIEF.md
# SPI Slave-Select Controller

This block drives the slave-select lines of an SPI master. A binary index picks one of the lines. All the other lines stay at a programmable idle level. Ownership of the chosen line can go to one of two places. Under software ownership, a level input drives the pin directly. Under hardware ownership, the line is asserted around each burst that the transfer engine runs.

Under hardware ownership, the line goes active in the cycle after the engine raises its burst-active signal. After the engine strobes burst-done, the line stays active for a fixed tail of clock cycles. The engine holds off its first serial clock edge by the same lead time. An optional hold mode keeps the line asserted after the tail, so that several bursts form one frame. Each hardware release sets a sticky deselect flag. A write-one-to-clear strobe clears the flag.

Top module: `spi_cs_ctrl`

## Requirements
- R1: Every select line other than the one addressed by `sel` (binary index i drives `ss[i]`) always sits at the idle level given by `idle_pol`.
- R2: While `owner_sw` is 1, the addressed line equals `sw_level` in the same cycle, with no register in the path.
- R3: While `owner_sw` is 0, `burst_active` sampled high at a rising edge from the idle condition drives the addressed line to the active level (`~idle_pol`) from that edge on.
- R4: With `hold_en` at 0, a `burst_done` strobe sampled at edge m keeps the addressed line active through edge m+TAIL_CYC-1. The line returns to idle at edge m+TAIL_CYC.
- R5: With `hold_en` at 1, the line stays active after the tail, and a following burst runs with no idle gap. The line is released at the first edge that samples `hold_en` low.
- R6: Each hardware release sets `deselect_flag` at the same edge as the line returns to idle. The flag then stays at 1 until it is cleared.
- R7: `flag_clr` sampled high clears `deselect_flag`. A release at the same edge takes priority, and the flag stays at 1.
- R8: Setting `owner_sw` to 1 while hardware holds the line ends the hardware assertion without setting `deselect_flag`. On return to hardware ownership, the line is at idle.
- R9: After reset, every line is at the idle level and `deselect_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| owner_sw | input | 1 | 1: software drives the addressed line; 0: the burst engine drives it |
| sel | input | SEL_W | Binary index of the addressed select line |
| sw_level | input | 1 | Pin level of the addressed line under software ownership |
| idle_pol | input | 1 | Deasserted level of all select lines |
| hold_en | input | 1 | Keep the line asserted between hardware bursts |
| burst_active | input | 1 | The engine is running, or is about to start, a burst |
| burst_done | input | 1 | One-cycle strobe at the last serial edge of a burst |
| flag_clr | input | 1 | Write-one-to-clear strobe for the deselect flag |
| ss | output | N_SS | Select line outputs |
| deselect_flag | output | 1 | Sticky flag, set on each hardware release |

## Verification
The assertions assume three things about the inputs. First, `sel` and `idle_pol` stay constant while hardware ownership has a line asserted. Second, `burst_done` arrives only while a burst is running. Third, `burst_active` is low during the tail unless a following burst is meant to start. The stimulus changes `sel` and `idle_pol` only while the controller is idle or under software ownership. It drops `burst_active` in the same cycle as it strobes `burst_done`. The sweeps cover every index with both idle polarities, and both software levels in software mode.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_BUSY = 2'd1,
      CS_TAIL = 2'd2,
      CS_HOLD = 2'd3
   } cs_state_e;
endpackage

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
   import spi_cs_pkg::*;
#(
   parameter int TAIL_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic owner_sw,
   input  logic hold_en,
   input  logic burst_active,
   input  logic burst_done,
   output logic hw_on,
   output logic release_evt
);
   localparam int CNT_W = $clog2(TAIL_CYC + 1);
   localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CYC - 1);

   cs_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d     = state_q;
      cnt_d       = cnt_q;
      release_evt = 1'b0;
      if (owner_sw) begin
         state_d = CS_IDLE;
      end else begin
         unique case (state_q)
            CS_IDLE: if (burst_active) state_d = CS_BUSY;
            CS_BUSY: if (burst_done) begin
               state_d = CS_TAIL;
               cnt_d   = TAIL_LOAD;
            end
            CS_TAIL: begin
               if (burst_active) begin
                  state_d = CS_BUSY;
               end else if (cnt_q == '0) begin
                  if (hold_en) begin
                     state_d = CS_HOLD;
                  end else begin
                     state_d     = CS_IDLE;
                     release_evt = 1'b1;
                  end
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            CS_HOLD: begin
               if (burst_active) begin
                  state_d = CS_BUSY;
               end else if (!hold_en) begin
                  state_d     = CS_IDLE;
                  release_evt = 1'b1;
               end
            end
            default: state_d = CS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign hw_on = (state_q != CS_IDLE);
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
   parameter int N_SS  = 4,
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             owner_sw,
   input  logic             sw_level,
   input  logic             idle_pol,
   input  logic             hw_on,
   output logic [N_SS-1:0]  ss
);
   logic chosen_level;

   always_comb begin
      if (owner_sw)   chosen_level = sw_level;
      else if (hw_on) chosen_level = ~idle_pol;
      else            chosen_level = idle_pol;
   end

   for (genvar i = 0; i < N_SS; i++) begin : g_line
      assign ss[i] = (sel == SEL_W'(i)) ? chosen_level : idle_pol;
   end
endmodule

// File: rtl/spi_cs_flag.sv
module spi_cs_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
   parameter int N_SS     = 4,
   parameter int TAIL_CYC = 2,
   parameter int SEL_W    = (N_SS > 1) ? $clog2(N_SS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             owner_sw,
   input  logic [SEL_W-1:0] sel,
   input  logic             sw_level,
   input  logic             idle_pol,
   input  logic             hold_en,
   input  logic             burst_active,
   input  logic             burst_done,
   input  logic             flag_clr,
   output logic [N_SS-1:0]  ss,
   output logic             deselect_flag
);
   if (N_SS < 2) begin : g_bad_nss
      $error("spi_cs_ctrl: N_SS must be at least 2");
   end
   if (TAIL_CYC < 1) begin : g_bad_tail
      $error("spi_cs_ctrl: TAIL_CYC must be at least 1");
   end
   if ((1 << SEL_W) < N_SS) begin : g_bad_sel
      $error("spi_cs_ctrl: SEL_W too narrow for N_SS");
   end

   logic hw_on;
   logic release_evt;

   spi_cs_seq #(.TAIL_CYC(TAIL_CYC)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .owner_sw     (owner_sw),
      .hold_en      (hold_en),
      .burst_active (burst_active),
      .burst_done   (burst_done),
      .hw_on        (hw_on),
      .release_evt  (release_evt)
   );

   spi_cs_drive #(.N_SS(N_SS), .SEL_W(SEL_W)) u_drive (
      .sel      (sel),
      .owner_sw (owner_sw),
      .sw_level (sw_level),
      .idle_pol (idle_pol),
      .hw_on    (hw_on),
      .ss       (ss)
   );

   spi_cs_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (release_evt),
      .clr     (flag_clr),
      .flag    (deselect_flag)
   );
endmodule

// File: rtl/spi_cs_ctrl_chk.sv
module spi_cs_ctrl_chk #(
   parameter int N_SS  = 4,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             owner_sw,
   input logic [SEL_W-1:0] sel,
   input logic             sw_level,
   input logic             idle_pol,
   input logic             burst_active,
   input logic             burst_done,
   input logic             flag_clr,
   input logic [N_SS-1:0]  ss,
   input logic             deselect_flag
);
   logic line_on;
   assign line_on = (ss[sel] != idle_pol);

   AST_UNSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ss ^ {N_SS{idle_pol}}) <= 1);  // R1

   AST_SW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      owner_sw |-> (ss[sel] == sw_level));  // R2

   AST_HW_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!owner_sw && burst_active) |=> (owner_sw || line_on));  // R3

   AST_TAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!owner_sw && burst_done) |=> (owner_sw || line_on));  // R4

   AST_RELEASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!owner_sw && $past(!owner_sw) && $stable(sel) && $stable(idle_pol)
       && $past(line_on) && !line_on) |-> deselect_flag);  // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (deselect_flag && !flag_clr) |=> deselect_flag);  // R7

   AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(deselect_flag) |-> $past(flag_clr));  // R7
endmodule

bind spi_cs_ctrl spi_cs_ctrl_chk #(.N_SS(N_SS), .SEL_W(SEL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .owner_sw      (owner_sw),
   .sel           (sel),
   .sw_level      (sw_level),
   .idle_pol      (idle_pol),
   .burst_active  (burst_active),
   .burst_done    (burst_done),
   .flag_clr      (flag_clr),
   .ss            (ss),
   .deselect_flag (deselect_flag)
);

// File: tb/tb_spi_cs_ctrl.sv
module tb_spi_cs_ctrl;
   localparam int N_SS     = 4;
   localparam int TAIL_CYC = 2;
   localparam int SEL_W    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic owner_sw = 1'b0, sw_level = 1'b1, idle_pol = 1'b1, hold_en = 1'b0;
   logic burst_active = 1'b0, burst_done = 1'b0, flag_clr = 1'b0;
   logic [SEL_W-1:0] sel = '0;
   logic [N_SS-1:0]  ss;
   logic             deselect_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   spi_cs_ctrl #(.N_SS(N_SS), .TAIL_CYC(TAIL_CYC)) dut (
      .clk(clk), .rst_n(rst_n), .owner_sw(owner_sw), .sel(sel),
      .sw_level(sw_level), .idle_pol(idle_pol), .hold_en(hold_en),
      .burst_active(burst_active), .burst_done(burst_done),
      .flag_clr(flag_clr), .ss(ss), .deselect_flag(deselect_flag)
   );

   function automatic logic [N_SS-1:0] exp_ss(input int s, input logic pol, input logic lvl);
      logic [N_SS-1:0] v = {N_SS{pol}};
      v[s] = lvl;
      return v;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      #1;
   endtask

   // one hardware burst lasting two cycles, ending with a done strobe
   task automatic hw_burst();
      burst_active = 1'b1;
      nxt();
      burst_active = 1'b0;
      burst_done   = 1'b1;
      nxt();
      burst_done   = 1'b0;
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      nxt();
      // R9: reset state
      chk("R9", 8'(ss), 8'({N_SS{1'b1}}));
      chk("R9", 8'(deselect_flag), 8'h0);
      rst_n = 1'b1;
      nxt();

      // R1 R2: software ownership, all index / polarity / level combinations
      owner_sw = 1'b1;
      for (int s = 0; s < N_SS; s++) begin
         for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < 2; l++) begin
               sel = SEL_W'(s); idle_pol = p[0]; sw_level = l[0];
               #1;
               chk("R2", 8'(ss), 8'(exp_ss(s, p[0], l[0])));
            end
         end
      end
      chk("R8", 8'(deselect_flag), 8'h0);
      nxt();
      owner_sw = 1'b0;

      // R3 R4 R6 R7: hardware bursts, hold off, every index and polarity
      for (int s = 0; s < N_SS; s++) begin
         for (int p = 0; p < 2; p++) begin
            sel = SEL_W'(s); idle_pol = p[0]; hold_en = 1'b0;
            #1;
            chk("R1", 8'(ss), 8'({N_SS{p[0]}}));
            burst_active = 1'b1;
            nxt();
            chk("R3", 8'(ss), 8'(exp_ss(s, p[0], ~p[0])));
            burst_active = 1'b0;
            burst_done   = 1'b1;
            nxt();
            burst_done = 1'b0;
            for (int j = 1; j < TAIL_CYC; j++) begin
               chk("R4", 8'(ss), 8'(exp_ss(s, p[0], ~p[0])));
               nxt();
            end
            chk("R4", 8'(ss), 8'(exp_ss(s, p[0], ~p[0])));
            nxt();
            chk("R4", 8'(ss), 8'({N_SS{p[0]}}));
            chk("R6", 8'(deselect_flag), 8'h1);
            nxt();
            chk("R6", 8'(deselect_flag), 8'h1);
            flag_clr = 1'b1;
            nxt();
            flag_clr = 1'b0;
            chk("R7", 8'(deselect_flag), 8'h0);
         end
      end

      // R5: hold mode across two bursts, then release
      sel = 2'd2; idle_pol = 1'b1; hold_en = 1'b1;
      nxt();
      hw_burst();
      for (int j = 0; j < TAIL_CYC + 3; j++) begin
         chk("R5", 8'(ss), 8'(exp_ss(2, 1'b1, 1'b0)));
         nxt();
      end
      chk("R5", 8'(deselect_flag), 8'h0);
      hw_burst();
      for (int j = 0; j < TAIL_CYC + 2; j++) begin
         chk("R5", 8'(ss), 8'(exp_ss(2, 1'b1, 1'b0)));
         nxt();
      end
      hold_en = 1'b0;
      nxt();
      chk("R5", 8'(ss), 8'hF);
      chk("R6", 8'(deselect_flag), 8'h1);
      flag_clr = 1'b1;
      nxt();
      flag_clr = 1'b0;

      // R7: release and clear at the same edge, release wins
      sel = 2'd1; idle_pol = 1'b0;
      burst_active = 1'b1;
      nxt();
      burst_active = 1'b0; burst_done = 1'b1;
      nxt();
      burst_done = 1'b0;
      for (int j = 1; j < TAIL_CYC; j++) nxt();
      flag_clr = 1'b1;
      nxt();
      flag_clr = 1'b0;
      chk("R7", 8'(ss), 8'h0);
      chk("R7", 8'(deselect_flag), 8'h1);
      flag_clr = 1'b1;
      nxt();
      flag_clr = 1'b0;
      chk("R7", 8'(deselect_flag), 8'h0);

      // R8: software takes over during a held burst
      sel = 2'd3; idle_pol = 1'b1; hold_en = 1'b1;
      nxt();
      hw_burst();
      chk("R8", 8'(ss), 8'(exp_ss(3, 1'b1, 1'b0)));
      owner_sw = 1'b1; sw_level = 1'b1;
      #1;
      chk("R8", 8'(ss), 8'hF);
      nxt();
      owner_sw = 1'b0;
      #1;
      chk("R8", 8'(ss), 8'hF);
      nxt();
      chk("R8", 8'(ss), 8'hF);
      chk("R8", 8'(deselect_flag), 8'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule